// File: doc/BRIEF.md
# Periodic Conversion-Start Pulse Timer

This block produces a steady train of short, active-high pulses meant for the start-of-conversion input of an analog-to-digital converter. The converter begins sampling on each rising edge, so the spacing of those edges sets the sample rate. A prescaler divides the input clock by 1, 8, 64 or 512. A counter then runs from zero up to a programmable period limit and wraps back to zero. The pin is high from count zero through the count equal to a programmable compare value, and low for the rest of the period. For example, a limit of 124, a compare of 1 and divide-by-64 give a pulse 128 clocks wide every 8000 clocks, which is a 2 kHz rate at 16 MHz.

A sticky status flag goes high in the clock where the pulse ends. A controller polls it to know when the conversion result can be fetched, and writes a one to the flag to clear it. Period and compare writes land in shadow registers. They reach the counter only at a wrap, or at once while the counter is stopped, so a period is never cut short and a pulse is never clipped.

The sequencer has three states. STOP holds the counter at zero. HIGH covers counts zero through the compare value. LOW covers the rest of the period. The transitions are:
- STOP->HIGH (start): the count enable is set.
- HIGH->LOW (match): a count step leaves the compare count while that count is not the period limit.
- LOW->HIGH (wrap): a count step leaves the period limit.
- HIGH->STOP and LOW->STOP (halt): the count enable is cleared.

HIGH stays in HIGH at a wrap when the compare value is at or above the limit.

Top module: `convstart_timer`

## Requirements
- R1: After reset the pulse output and the flag are 0, the counter is stopped, and the output stays low until a control write sets the count enable.
- R2: Control word, written at address 2: bit 0 is the count enable, bit 1 is the output enable, and bits 3:2 select the divide ratio (0 gives /1, 1 gives /8, 2 gives /64, 3 gives /512). Every count lasts exactly the divide ratio in clocks, including the first count after the counter starts.
- R3: The counter runs 0,1,...,P and wraps to 0, where P is the period value written at address 0. The pulse period is (P+1) times the divide ratio.
- R4: With compare value C written at address 1 and C below P, the pin is high for counts 0 through C, so each pulse is (C+1) times the divide ratio in clocks. That includes the first pulse after the counter starts.
- R5: The flag goes to 1 at the same clock edge at which the pin falls at the end of the compare count.
- R6: Writing data with bit 0 set to address 3 clears the flag. Writing data with bit 0 clear there leaves the flag unchanged.
- R7: If a clear write and a flag-setting event occur in the same clock, the flag ends up set.
- R8: Period and compare writes made while the counter runs do not change the period or pulse already in progress. They take effect from the next wrap. While the counter is stopped, they take effect at once.
- R9: With C greater than P, the pin stays high continuously and the flag never sets.
- R10: With the output enable clear, the pin is held low while the counter keeps running and the flag still sets.
- R11: Clearing the count enable drives the pin low and returns the counter to 0. Enabling it again starts a fresh full-width pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 period, 1 compare, 2 control, 3 flag clear |
| wr_data | input | 8 | Write data |
| pulse_o | output | 1 | Conversion-start pulse |
| flag_o | output | 1 | Pulse-ended status flag |

## Verification
The hardest case to reach from the ports is a clear write that lands in the very clock where the compare match sets the flag. The ports expose no counter value, so that edge has to be found by counting clocks. The stimulus uses divide-by-1, a period of 4 and a compare of 1, so the match falls exactly three edges after the enabling control write is sampled. The clear write is placed on that edge. The mid-period shadow writes are timed the same way: they follow the first rising edge by a known number of clocks, and the remainder of the old period is then measured.

// File: rtl/cst_pkg.sv
package cst_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } cst_state_e;

    localparam logic [1:0] ADDR_PERIOD  = 2'd0;
    localparam logic [1:0] ADDR_COMPARE = 2'd1;
    localparam logic [1:0] ADDR_CONTROL = 2'd2;
    localparam logic [1:0] ADDR_FLAG    = 2'd3;

    localparam int CTL_RUN_BIT = 0;
    localparam int CTL_OE_BIT  = 1;
    localparam int CTL_SEL_LSB = 2;

endpackage

// File: rtl/cst_prescaler.sv
module cst_prescaler #(
    parameter int SEL_W = 2,
    parameter int STEP  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NSEL  = 1 << SEL_W;
    localparam int PRE_W = STEP * (NSEL - 1) + 1;

    logic [PRE_W-1:0] pre;
    logic [NSEL-1:0]  hit;

    // One terminal comparator per divide ratio; ratio g is 2**(STEP*g)
    for (genvar g = 0; g < NSEL; g++) begin : g_term
        assign hit[g] = (pre == PRE_W'((64'd1 << (STEP * g)) - 64'd1));
    end

    assign tick = run & hit[sel];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre <= '0;
        end else if (tick) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // R2: any ratio above 1 never yields back-to-back ticks
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick && sel != '0 |=> !tick || sel != $past(sel) || !run);

endmodule

// File: rtl/cst_counter.sv
module cst_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] period_sh,
    input  logic [CNT_W-1:0] compare_sh,
    output logic [CNT_W-1:0] cnt,
    output logic             at_top,
    output logic             at_cmp
);
    logic [CNT_W-1:0] period_act;
    logic [CNT_W-1:0] compare_act;
    logic             wrap;

    assign at_top = (cnt == period_act);
    assign at_cmp = (cnt == compare_act);
    assign wrap   = tick && at_top;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= at_top ? '0 : cnt + 1'b1;
        end
    end

    // Shadow values reach the active pair when stopped or at a wrap
    always_ff @(posedge clk) begin
        if (rst) begin
            period_act  <= '1;
            compare_act <= '0;
        end else if (!run || wrap) begin
            period_act  <= period_sh;
            compare_act <= compare_sh;
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt <= period_act);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        run && !tick |=> $stable(cnt));

    // R8
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        run && !wrap |=> $stable(period_act) && $stable(compare_act));

endmodule

// File: rtl/cst_fsm.sv
module cst_fsm
    import cst_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic at_cmp,
    input  logic at_top,
    output logic active_o,
    output logic high_o,
    output logic set_evt_o
);
    cst_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_STOP;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_STOP: begin
                if (run) nxt = ST_HIGH;
            end
            ST_HIGH: begin
                if (!run) begin
                    nxt = ST_STOP;
                end else if (tick && at_cmp && !at_top) begin
                    nxt = ST_LOW;
                end
            end
            ST_LOW: begin
                if (!run) begin
                    nxt = ST_STOP;
                end else if (tick && at_top) begin
                    nxt = ST_HIGH;
                end
            end
            default: nxt = ST_STOP;
        endcase
    end

    always_comb begin
        active_o  = (state != ST_STOP);
        high_o    = (state == ST_HIGH);
        set_evt_o = (state == ST_HIGH) && tick && at_cmp;
    end

    // R5
    fall_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(high_o) && $past(run) |-> $past(set_evt_o));

    // R11
    halt_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !high_o);

endmodule

// File: rtl/cst_regs.sv
module cst_regs
    import cst_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             set_evt,
    output logic [CNT_W-1:0] period_sh,
    output logic [CNT_W-1:0] compare_sh,
    output logic             run,
    output logic             oe,
    output logic [SEL_W-1:0] sel,
    output logic             flag
);
    logic clr_req;

    assign clr_req = wr_en && (wr_addr == ADDR_FLAG) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            period_sh  <= '1;
            compare_sh <= '0;
            run        <= 1'b0;
            oe         <= 1'b0;
            sel        <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_PERIOD:  period_sh  <= wr_data;
                ADDR_COMPARE: compare_sh <= wr_data;
                ADDR_CONTROL: begin
                    run <= wr_data[CTL_RUN_BIT];
                    oe  <= wr_data[CTL_OE_BIT];
                    sel <= wr_data[CTL_SEL_LSB +: SEL_W];
                end
                default: ;
            endcase
        end
    end

    // Setting outranks clearing
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag);

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_req && !set_evt |=> !flag);

    // R6
    zero_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr == ADDR_FLAG && !wr_data[0] && !set_evt |=> $stable(flag));

endmodule

// File: rtl/convstart_timer.sv
module convstart_timer #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 2,
    parameter int STEP  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pulse_o,
    output logic             flag_o
);
    logic [CNT_W-1:0] period_sh, compare_sh, cnt;
    logic             run, oe, tick, active, high, set_evt, at_top, at_cmp;
    logic [SEL_W-1:0] sel;

    cst_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .set_evt    (set_evt),
        .period_sh  (period_sh),
        .compare_sh (compare_sh),
        .run        (run),
        .oe         (oe),
        .sel        (sel),
        .flag       (flag_o)
    );

    cst_prescaler #(.SEL_W(SEL_W), .STEP(STEP)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (active),
        .sel  (sel),
        .tick (tick)
    );

    cst_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .run        (active),
        .tick       (tick),
        .period_sh  (period_sh),
        .compare_sh (compare_sh),
        .cnt        (cnt),
        .at_top     (at_top),
        .at_cmp     (at_cmp)
    );

    cst_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .tick      (tick),
        .at_cmp    (at_cmp),
        .at_top    (at_top),
        .active_o  (active),
        .high_o    (high),
        .set_evt_o (set_evt)
    );

    assign pulse_o = high && oe;

    // R4
    rise_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(high) |-> cnt == '0);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> !pulse_o && !flag_o);

endmodule

// File: tb/sim_convstart_timer.sv
module sim_convstart_timer;

    typedef struct packed {
        logic [7:0] top;
        logic [7:0] cmp;
        logic [1:0] sel;
        int         hi;
        int         per;
    } vec_t;

    localparam int   NV  = 4;
    localparam int   LIM = 20000;
    localparam vec_t VECS [NV] = '{
        '{top: 8'd124, cmp: 8'd1,  sel: 2'd2, hi: 128, per: 8000},
        '{top: 8'd9,   cmp: 8'd3,  sel: 2'd1, hi: 32,  per: 80},
        '{top: 8'd4,   cmp: 8'd0,  sel: 2'd0, hi: 1,   per: 5},
        '{top: 8'd20,  cmp: 8'd10, sel: 2'd0, hi: 11,  per: 21}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pulse_o, flag_o;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    convstart_timer u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pulse_o (pulse_o),
        .flag_o  (flag_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the sampling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rise();
        int t = 0;
        while (pulse_o !== 1'b0 && t < LIM) begin @(negedge clk); t++; end
        while (pulse_o !== 1'b1 && t < LIM) begin @(negedge clk); t++; end
    endtask

    // Starts at the negedge where the pulse was first seen high
    task automatic measure(output int hi, output int per);
        int t = 0;
        hi = 0; per = 0;
        while (pulse_o === 1'b1 && t < LIM) begin hi++; per++; @(negedge clk); t++; end
        while (pulse_o === 1'b0 && t < LIM) begin per++; @(negedge clk); t++; end
    endtask

    initial begin
        int hi, per, ones;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        chk(pulse_o === 1'b0, "R1 pulse after reset", int'(pulse_o), 0);
        chk(flag_o === 1'b0, "R1 flag after reset", int'(flag_o), 0);
        ones = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (pulse_o) ones++; end
        chk(ones == 0, "R1 no pulse while stopped", ones, 0);

        // Table walk: R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            wr(2'd2, 8'd0);
            wr(2'd0, VECS[v].top);
            wr(2'd1, VECS[v].cmp);
            wr(2'd2, {4'd0, VECS[v].sel, 2'b11});
            wait_rise();
            measure(hi, per);
            chk(hi == VECS[v].hi, "R4 first pulse width", hi, VECS[v].hi);
            chk(per == VECS[v].per, "R2 first period", per, VECS[v].per);
            measure(hi, per);
            chk(hi == VECS[v].hi, "R4 steady pulse width", hi, VECS[v].hi);
            chk(per == VECS[v].per, "R3 steady period", per, VECS[v].per);
        end

        // R5: flag rises on the edge the pulse falls
        wr(2'd2, 8'd0);
        wr(2'd3, 8'd1);
        chk(flag_o === 1'b0, "R6 clear while stopped", int'(flag_o), 0);
        wr(2'd0, 8'd9);
        wr(2'd1, 8'd3);
        wr(2'd2, 8'b0000_0111);
        wait_rise();
        while (pulse_o === 1'b1) begin
            if (flag_o !== 1'b0) break;
            @(negedge clk);
        end
        chk(pulse_o === 1'b0 && flag_o === 1'b1, "R5 flag set as pulse falls", int'(flag_o), 1);

        // R7: clear write on the very edge of the set event
        wr(2'd2, 8'd0);
        wr(2'd3, 8'd1);
        wr(2'd0, 8'd4);
        wr(2'd1, 8'd1);
        wr(2'd2, 8'b0000_0011);
        @(negedge clk);
        @(negedge clk);
        chk(pulse_o === 1'b1 && flag_o === 1'b0, "R4 high before match", int'(pulse_o), 1);
        wr(2'd3, 8'd1);
        chk(flag_o === 1'b1, "R7 set wins over clear", int'(flag_o), 1);
        chk(pulse_o === 1'b0, "R5 pulse fell at match", int'(pulse_o), 0);

        // R6: zero write keeps flag, one write clears
        wr(2'd2, 8'd0);
        wr(2'd3, 8'd0);
        chk(flag_o === 1'b1, "R6 zero write no effect", int'(flag_o), 1);
        wr(2'd3, 8'd1);
        chk(flag_o === 1'b0, "R6 one write clears", int'(flag_o), 0);

        // R8: mid-period shadow writes
        wr(2'd0, 8'd19);
        wr(2'd1, 8'd4);
        wr(2'd2, 8'b0000_0011);
        wait_rise();
        wr(2'd1, 8'd8);
        wr(2'd0, 8'd9);
        measure(hi, per);
        chk(hi + 2 == 5, "R8 current pulse kept", hi + 2, 5);
        chk(per + 2 == 20, "R8 current period kept", per + 2, 20);
        measure(hi, per);
        chk(hi == 9, "R8 new pulse width", hi, 9);
        chk(per == 10, "R8 new period", per, 10);

        // R9: compare above period
        wr(2'd2, 8'd0);
        wr(2'd3, 8'd1);
        wr(2'd0, 8'd5);
        wr(2'd1, 8'd9);
        wr(2'd2, 8'b0000_0011);
        wait_rise();
        ones = 0;
        for (int i = 0; i < 40; i++) begin if (pulse_o === 1'b1) ones++; @(negedge clk); end
        chk(ones == 40, "R9 pulse stays high", ones, 40);
        chk(flag_o === 1'b0, "R9 flag never set", int'(flag_o), 0);

        // R10: output disabled
        wr(2'd2, 8'd0);
        wr(2'd3, 8'd1);
        wr(2'd0, 8'd4);
        wr(2'd1, 8'd1);
        wr(2'd2, 8'b0000_0001);
        ones = 0;
        for (int i = 0; i < 20; i++) begin if (pulse_o !== 1'b0) ones++; @(negedge clk); end
        chk(ones == 0, "R10 pin held low", ones, 0);
        chk(flag_o === 1'b1, "R10 flag still sets", int'(flag_o), 1);

        // R11: halt mid-pulse, restart fresh
        wr(2'd2, 8'd0);
        wr(2'd0, 8'd9);
        wr(2'd1, 8'd3);
        wr(2'd2, 8'b0000_0111);
        wait_rise();
        repeat (3) @(negedge clk);
        wr(2'd2, 8'b0000_0110);
        @(negedge clk);
        chk(pulse_o === 1'b0, "R11 pin low when halted", int'(pulse_o), 0);
        wr(2'd2, 8'b0000_0111);
        wait_rise();
        measure(hi, per);
        chk(hi == 32, "R11 fresh pulse width", hi, 32);
        chk(per == 80, "R11 fresh period", per, 80);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule